// File: doc/BRIEF.md
# Multi-Resolution PWM Timer Unit

This block is a PWM generator with several compare channels and one shared timebase. The timebase advances once per pulse of a one-cycle clock-enable input. It runs over a cycle of 8, 9, 10 or 11 bits, and the length is chosen globally, so every channel uses the same one. Each channel drives one PWM output and keeps a sticky match flag. Each channel can run edge-aligned, where the counter view is a sawtooth, or center-aligned, where the view is a triangle. A global sticky overflow flag records every counter wrap.

Software reaches the unit through a byte-wide register bus. Duty updates go through shadow registers and are copied into the active compare value only at a cycle boundary, so the output never glitches. In 8-bit mode the high compare byte is the shadow of the low byte. In the longer modes a separate 16-bit reload register is mapped onto the two compare byte addresses, and a control bit selects which of the two is seen.

The timebase is a two-state machine. In `TB_RISE` the counter climbs through the first half of a center-aligned period. In `TB_FALL` it climbs through the second half, which center-aligned channels read mirrored. The transition `TB_RISE -> TB_FALL` happens on a wrap at the top of the triangle, called the down edge. The transition `TB_FALL -> TB_RISE` happens on a wrap at the bottom of the triangle, called the up edge. When no wrap occurs, each state stays where it is. Edge-aligned channels ignore the state. Their period is 2^N ticks, and a center-aligned period is 2^(N+1) ticks.

Top module: `pwm_unit`

## Requirements
- R1: After reset, every register reads zero, all PWM outputs are low, and all flags are clear.
- R2: The counter moves only on a clock edge where `tick` is high. The length code in control bits [1:0] selects N = 8 + code. The counter steps from 2^N-1 back to 0.
- R3: Every counter wrap sets the overflow flag, which appears on `ovf_flag` and in status bit 0. Writing a 1 to status bit 0 clears it. A wrap in the same cycle wins over the clear.
- R4: A channel is active only while mode bit 0 (compare enable) and mode bit 1 (PWM) are both 1. An inactive channel drives its output low.
- R5: An edge-aligned channel (mode bit 3 = 0) drives its output high while the count is greater than or equal to the duty value. The output is registered, so it follows the count one clock later.
- R6: A center-aligned channel (mode bit 3 = 1) compares the duty value against the count in `TB_RISE` and against 2^N-1 minus the count in `TB_FALL`.
- R7: In 8-bit mode the duty value is the compare low byte. The low byte is loaded from the compare high byte at the channel's reload point: a wrap for edge-aligned channels, an up edge for center-aligned channels. A bus write to the low byte in that same cycle wins.
- R8: In 9 to 11 bit modes the duty value is the low N bits of the 16-bit compare value. At the reload point the whole compare value is loaded from the reload register. Control bit 2 routes reads and writes at the low and high byte addresses to the reload register when it is 1, and to the compare register when it is 0.
- R9: When mode bit 2 is set, an active channel sets its flag (status bit 1+c) when its output rises in edge-aligned mode, or at an up edge in center-aligned mode. The flag stays set until a 1 is written to that status bit.
- R10: A write to a channel's low byte address clears mode bit 0. A write to its high byte address sets mode bit 0.
- R11: The register map is: address 0 is control ({arsel, len}), address 1 is status, and channel c has mode at 4(c+1), low byte at 4(c+1)+1, high byte at 4(c+1)+2. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase advance enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pwm_out | output | NCH | Per-channel PWM outputs |
| ch_flag | output | NCH | Per-channel sticky match flags |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The counter, the reload copies, the flags and the register writes all take effect at the clock edge that sees their cause. The PWM outputs come one clock later, because each output is the registered result of comparing the count and duty values held during the previous cycle. The bench drives inputs just after a rising edge and updates its behavioural model at the next rising edge. It then compares outputs, flags and read data at the following falling edge, so every result is sampled in the cycle it is due. Directed reads check the reload copies only after enough ticks have passed to guarantee a reload point.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int MIN_BITS = 8;
    localparam int CW       = MIN_BITS + 3;

    typedef enum logic {
        TB_RISE = 1'b0,
        TB_FALL = 1'b1
    } tb_state_e;

    typedef struct packed {
        logic center;
        logic match_en;
        logic pwm_en;
        logic cmp_en;
    } ch_mode_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    len,
    output logic [CW-1:0] count,
    output tb_state_e     half,
    output logic [CW-1:0] top,
    output logic          wrap_ev,
    output logic          bottom_ev
);
    tb_state_e     half_n;
    logic [CW-1:0] count_n;

    always_comb begin
        top       = CW'((1 << (MIN_BITS + int'(len))) - 1);
        wrap_ev   = tick && (count >= top);
        bottom_ev = wrap_ev && (half == TB_FALL);
    end

    always_comb begin
        half_n = half;
        unique case (half)
            TB_RISE: if (wrap_ev) half_n = TB_FALL;
            TB_FALL: if (wrap_ev) half_n = TB_RISE;
        endcase
        if (!tick)        count_n = count;
        else if (wrap_ev) count_n = '0;
        else              count_n = count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half  <= TB_RISE;
            count <= '0;
        end else begin
            half  <= half_n;
            count <= count_n;
        end
    end

    p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(count) && $stable(half)));
    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_ev |=> (count == '0));
    p_half_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_ev |=> (half != $past(half)));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    len,
    input  logic          arsel,
    input  logic [7:0]    wdata,
    input  logic          wr_mode,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic          flag_clr,
    input  logic [CW-1:0] count,
    input  tb_state_e     half,
    input  logic [CW-1:0] top,
    input  logic          wrap_ev,
    input  logic          bottom_ev,
    output logic          pwm_q,
    output logic          flag,
    output logic [7:0]    mode_rd,
    output logic [7:0]    lo_rd,
    output logic [7:0]    hi_rd
);
    ch_mode_t      mode;
    logic [15:0]   cmp;
    logic [15:0]   arr;
    logic          active;
    logic          reload;
    logic          hit;
    logic          match_set;
    logic [CW-1:0] view;
    logic [CW-1:0] duty;

    always_comb begin
        active    = mode.cmp_en && mode.pwm_en;
        view      = (mode.center && half == TB_FALL) ? (top - count) : count;
        duty      = (len == 2'd0) ? {{(CW-8){1'b0}}, cmp[7:0]} : (cmp[CW-1:0] & top);
        hit       = active && (view >= duty);
        reload    = mode.center ? bottom_ev : wrap_ev;
        match_set = active && mode.match_en && (mode.center ? bottom_ev : (hit && !pwm_q));
        mode_rd   = {4'b0, mode};
        lo_rd     = arsel ? arr[7:0]  : cmp[7:0];
        hi_rd     = arsel ? arr[15:8] : cmp[15:8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            cmp   <= '0;
            arr   <= '0;
            pwm_q <= 1'b0;
            flag  <= 1'b0;
        end else begin
            pwm_q <= hit;
            flag  <= (flag && !flag_clr) || match_set;
            if (wr_mode)    mode        <= ch_mode_t'(wdata[3:0]);
            else if (wr_lo) mode.cmp_en <= 1'b0;
            else if (wr_hi) mode.cmp_en <= 1'b1;
            if (wr_lo && !arsel) cmp[7:0] <= wdata;
            else if (reload)     cmp[7:0] <= (len == 2'd0) ? cmp[15:8] : arr[7:0];
            if (wr_hi && !arsel)              cmp[15:8] <= wdata;
            else if (reload && len != 2'd0)   cmp[15:8] <= arr[15:8];
            if (wr_lo && arsel) arr[7:0]  <= wdata;
            if (wr_hi && arsel) arr[15:8] <= wdata;
        end
    end

    p_off_output_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pwm_q);
    p_lo_write_clears_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !mode.cmp_en);
    p_hi_write_sets_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> mode.cmp_en);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
    p_byte_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && len == 2'd0 && !wr_lo && !wr_hi) |=> (cmp[7:0] == $past(cmp[15:8])));
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = $clog2(4 * (NCH + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    ch_flag,
    output logic              ovf_flag
);
    logic [1:0]    len;
    logic          arsel;
    logic          ctrl_wr;
    logic          stat_wr;
    logic [CW-1:0] count;
    logic [CW-1:0] top;
    tb_state_e     half;
    logic          wrap_ev;
    logic          bottom_ev;
    logic [7:0]    mode_rd [NCH];
    logic [7:0]    lo_rd   [NCH];
    logic [7:0]    hi_rd   [NCH];

    assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(0));
    assign stat_wr = bus_we && (bus_addr == ADDR_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len      <= '0;
            arsel    <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                len   <= bus_wdata[1:0];
                arsel <= bus_wdata[2];
            end
            ovf_flag <= (ovf_flag && !(stat_wr && bus_wdata[0])) || wrap_ev;
        end
    end

    pwm_timebase u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .len       (len),
        .count     (count),
        .half      (half),
        .top       (top),
        .wrap_ev   (wrap_ev),
        .bottom_ev (bottom_ev)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * (c + 1));
        pwm_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .len       (len),
            .arsel     (arsel),
            .wdata     (bus_wdata),
            .wr_mode   (bus_we && bus_addr == BASE),
            .wr_lo     (bus_we && bus_addr == BASE + ADDR_W'(1)),
            .wr_hi     (bus_we && bus_addr == BASE + ADDR_W'(2)),
            .flag_clr  (stat_wr && bus_wdata[c + 1]),
            .count     (count),
            .half      (half),
            .top       (top),
            .wrap_ev   (wrap_ev),
            .bottom_ev (bottom_ev),
            .pwm_q     (pwm_out[c]),
            .flag      (ch_flag[c]),
            .mode_rd   (mode_rd[c]),
            .lo_rd     (lo_rd[c]),
            .hi_rd     (hi_rd[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(0)) bus_rdata = {5'b0, arsel, len};
        if (bus_addr == ADDR_W'(1)) bus_rdata = 8'({ch_flag, ovf_flag});
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == ADDR_W'(4 * (c + 1)))     bus_rdata = mode_rd[c];
            if (bus_addr == ADDR_W'(4 * (c + 1) + 1)) bus_rdata = lo_rd[c];
            if (bus_addr == ADDR_W'(4 * (c + 1) + 2)) bus_rdata = hi_rd[c];
        end
    end

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_ev |=> ovf_flag);
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !stat_wr) |=> ovf_flag);
endmodule

// File: tb/sim_pwm_unit.sv
module sim_pwm_unit;
    localparam int PERIOD = 10;
    localparam int NCH    = 2;
    localparam int AW     = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b0;
    logic           bus_we = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] pwm_out;
    logic [NCH-1:0] ch_flag;
    logic           ovf_flag;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int tick_div = 0;
    bit live = 0;

    int m_len, m_arsel, m_ovf, m_cnt, m_half;
    int m_mode [NCH];
    int m_cmp  [NCH];
    int m_arr  [NCH];
    int m_flag [NCH];
    int m_out  [NCH];

    pwm_unit #(.NCH(NCH), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .ch_flag(ch_flag), .ovf_flag(ovf_flag)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int model_read(int a);
        int r;
        r = 0;
        if (a == 0) r = (m_arsel << 2) | m_len;
        if (a == 1) begin
            r = m_ovf;
            for (int c = 0; c < NCH; c++) r |= m_flag[c] << (c + 1);
        end
        for (int c = 0; c < NCH; c++) begin
            if (a == 4 * (c + 1))     r = m_mode[c];
            if (a == 4 * (c + 1) + 1) r = m_arsel ? (m_arr[c] & 255) : (m_cmp[c] & 255);
            if (a == 4 * (c + 1) + 2) r = m_arsel ? (m_arr[c] >> 8)  : (m_cmp[c] >> 8);
        end
        return r;
    endfunction

    // Behavioural reference, advanced once per rising edge from old state
    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 0; m_arsel = 0; m_ovf = 0; m_cnt = 0; m_half = 0;
            for (int c = 0; c < NCH; c++) begin
                m_mode[c] = 0; m_cmp[c] = 0; m_arr[c] = 0; m_flag[c] = 0; m_out[c] = 0;
            end
        end else begin
            int top, wd, a;
            bit wrap, bottom, we;
            top    = (1 << (8 + m_len)) - 1;
            wrap   = tick && (m_cnt >= top);
            bottom = wrap && (m_half == 1);
            we = bus_we; a = int'(bus_addr); wd = int'(bus_wdata);
            for (int c = 0; c < NCH; c++) begin
                int b, md, view, duty, lo, hi, ar;
                bit act, cen, hit, mset, rel, wlo, whi, clr;
                b    = 4 * (c + 1);
                md   = m_mode[c];
                act  = (md & 3) == 3;
                cen  = (md >> 3) & 1;
                view = (cen && m_half == 1) ? top - m_cnt : m_cnt;
                duty = (m_len == 0) ? (m_cmp[c] & 255) : (m_cmp[c] & top);
                hit  = act && (view >= duty);
                mset = act && ((md >> 2) & 1) && (cen ? bottom : (hit && !m_out[c]));
                rel  = cen ? bottom : wrap;
                clr  = we && a == 1 && ((wd >> (c + 1)) & 1);
                wlo  = we && a == b + 1;
                whi  = we && a == b + 2;
                m_flag[c] = (m_flag[c] && !clr) || mset;
                m_out[c]  = hit;
                if (we && a == b) m_mode[c] = wd & 15;
                else if (wlo)     m_mode[c] = md & ~1;
                else if (whi)     m_mode[c] = md | 1;
                ar = m_arr[c];
                lo = m_cmp[c] & 255;
                hi = m_cmp[c] >> 8;
                if (wlo && !m_arsel) lo = wd;
                else if (rel)        lo = (m_len == 0) ? (m_cmp[c] >> 8) : (ar & 255);
                if (whi && !m_arsel)           hi = wd;
                else if (rel && m_len != 0)    hi = ar >> 8;
                m_cmp[c] = (hi << 8) | lo;
                if (wlo && m_arsel) ar = (ar & 'hFF00) | wd;
                if (whi && m_arsel) ar = (ar & 'h00FF) | (wd << 8);
                m_arr[c] = ar;
            end
            m_ovf = (m_ovf && !(we && a == 1 && (wd & 1))) || wrap;
            if (we && a == 0) begin
                m_len   = wd & 3;
                m_arsel = (wd >> 2) & 1;
            end
            if (tick) begin
                if (wrap) begin m_cnt = 0; m_half = 1 - m_half; end
                else m_cnt = m_cnt + 1;
            end
        end
    end

    // Tick pattern and watchdog
    always @(posedge clk) begin
        cyc++;
        #1;
        tick <= (tick_div == 1) || (tick_div > 1 && (cyc % tick_div) == 0);
        if (cyc > 150000) begin
            miscompares++;
            $display("FAIL R2 watchdog expired actual=%0d expected=finish", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            for (int c = 0; c < NCH; c++) begin
                string tag;
                tag = ((m_mode[c] & 3) != 3) ? "R4" : (((m_mode[c] >> 3) & 1) ? "R6" : "R5");
                chk({tag, " pwm_out"}, int'(pwm_out[c]), m_out[c]);
                chk("R9 ch_flag", int'(ch_flag[c]), m_flag[c]);
            end
            chk("R3 ovf_flag", int'(ovf_flag), m_ovf);
            chk("R11 bus_rdata", int'(bus_rdata), model_read(int'(bus_addr)));
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #2;
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = 8'(d);
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic rd(string tag, int a, int exp);
        @(posedge clk); #2;
        bus_addr = AW'(a);
        @(negedge clk);
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [NCH-1:0] held;
        run(3);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwm_out reset", int'(pwm_out), 0);
        chk("R1 flags reset", int'({ch_flag, ovf_flag}), 0);
        chk("R1 rdata reset", int'(bus_rdata), 0);
        live = 1;

        // 8-bit: ch0 edge at 0x40, ch1 center at 0x80
        tick_div = 1;
        wr(6, 'h40);
        wr(4, 'h7);
        wr(10, 'h80);
        wr(8, 'hF);
        run(700);
        rd("R7 low byte reloaded from high", 5, 'h40);

        // enable side effects of byte writes
        wr(5, 'h10);
        rd("R10 low write clears enable", 4, 'h6);
        wr(6, 'h20);
        rd("R10 high write sets enable", 4, 'h7);
        run(600);
        wr(1, 'hFF);
        tick_div = 3;
        run(2000);

        // tick held low: nothing moves
        tick_div = 0;
        run(3);
        @(negedge clk);
        held = pwm_out;
        run(60);
        @(negedge clk);
        chk("R2 outputs frozen without tick", int'(pwm_out), int'(held));
        tick_div = 1;

        // 10-bit with reload registers
        wr(0, 'h6);
        wr(5, 'h2C);
        wr(6, 'h01);
        rd("R8 reload low readback", 5, 'h2C);
        rd("R8 reload high readback", 6, 'h01);
        wr(0, 'h2);
        run(2200);
        rd("R8 compare low after reload", 5, 'h2C);
        rd("R8 compare high after reload", 6, 'h01);

        // 11-bit, ch1 duty at the top value
        wr(0, 'h7);
        wr(9, 'hFF);
        wr(10, 'h07);
        wr(0, 'h3);
        run(9000);
        tick_div = 2;
        wr(1, 'hFF);
        run(9000);

        // ch0 PWM bit cleared
        wr(4, 'hD);
        run(300);
        rd("R11 control readback", 0, 'h3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule